// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides whether a short relative branch is taken and gives back the program counter that follows it, for a processor with a 24-bit code address. Each request carries the current PC, a signed 8-bit displacement, a 4-bit condition selector, the four status flags (carry, zero, negative, overflow) and, for the decrement-and-loop form, the already decremented counter value with a byte/word size flag. The displacement counts 2-byte units. A taken target is kept inside the 24-bit space and is always even. When the branch is not taken, the incoming PC is returned unmodified.

Requests enter on a valid/ready port and results leave on a valid/ready port, with one register stage in between. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output at the next edge. The input is ready whenever the output register is empty or is being drained in that same cycle, so a full stream moves one result per clock. When `out_ready` is held low, the result stays put and new requests stall.

Top module: `brr_unit`

## Requirements
- R1: A taken target equals the PC plus the displacement byte read as a two's-complement number and multiplied by two.
- R2: A taken target is reduced modulo 2^24 and has bit 0 cleared (for example PC 0x000000 with displacement 0xFF gives 0xFFFFFE, and PC 0xFFFFFF with displacement 0x01 gives 0x000000).
- R3: Selector 1 is taken when C=0. Selector 2 is taken when C=1. Selector 3 is taken when Z=1. Selector 4 is taken when Z=0.
- R4: Selector 0 is always taken, whatever the flags are.
- R5: Selector 5 is taken when N=1, selector 6 when N=0, selector 7 when V=1 and selector 8 when V=0.
- R6: Selector 9 is taken when C=0 and Z=0. Selector 10 is taken when C=1 or Z=1.
- R7: Selector 11 is taken when N equals V and selector 12 when N differs from V. Selector 13 is taken when Z=0 and N equals V. Selector 14 is taken when Z=1 or N differs from V.
- R8: When the branch is not taken, the output PC equals the input PC bit for bit, including an odd bit 0, and `out_taken` is 0.
- R9: Selector 15 is taken when the counter is non-zero. With the word flag high, all 16 bits are tested; with it low, only bits 7:0 are tested.
- R10: `in_ready` is high exactly when the output register is empty or `out_ready` is high. An accepted request shows `out_valid` at the next edge. After reset the output is empty.
- R11: While `out_valid` is high and `out_ready` is low, `out_pc` and `out_taken` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 24 | PC of the branch |
| in_disp | input | 8 | Signed displacement in 2-byte units |
| in_cond | input | 4 | Condition selector (0 to 15, see R3 to R9) |
| in_flag_c | input | 1 | Carry flag |
| in_flag_z | input | 1 | Zero flag |
| in_flag_n | input | 1 | Negative flag |
| in_flag_v | input | 1 | Overflow flag |
| in_dec_val | input | 16 | Decremented loop counter |
| in_dec_word | input | 1 | 1: test 16 bits, 0: test bits 7:0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pc | output | 24 | Next PC |
| out_taken | output | 1 | Branch was taken |

## Verification
Accepting a new request and handing off the held result can happen in the same cycle. This is the path that moves one result per clock, and it is also where an off-by-one in the ready logic would drop or duplicate a result. The bench keeps `in_valid` high for long stretches while it toggles `out_ready` at random, so some edges only accept, some only drain, some do both and some stall. On every clock the bench compares `in_ready`, `out_valid`, `out_pc` and `out_taken` against a single-slot reference model that is updated by the same handshake rules.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [3:0] {
    BC_ALWAYS  = 4'd0,
    BC_C_CLR   = 4'd1,
    BC_C_SET   = 4'd2,
    BC_Z_SET   = 4'd3,
    BC_Z_CLR   = 4'd4,
    BC_N_SET   = 4'd5,
    BC_N_CLR   = 4'd6,
    BC_V_SET   = 4'd7,
    BC_V_CLR   = 4'd8,
    BC_U_HI    = 4'd9,
    BC_U_LS    = 4'd10,
    BC_S_GE    = 4'd11,
    BC_S_LT    = 4'd12,
    BC_S_GT    = 4'd13,
    BC_S_LE    = 4'd14,
    BC_DEC_NZ  = 4'd15
  } brcond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } brflags_t;
endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  brr_pkg::brcond_e  cond,
  input  brr_pkg::brflags_t flags,
  input  logic [DATA_W-1:0] dec_val,
  input  logic              dec_word,
  output logic              taken
);
  import brr_pkg::*;

  logic sgn_ok;   // N equals V
  logic cnt_nz;

  assign sgn_ok = (flags.n == flags.v);
  assign cnt_nz = dec_word ? (|dec_val) : (|dec_val[BYTE_W-1:0]);

  always_comb begin
    unique case (cond)
      BC_ALWAYS: taken = 1'b1;
      BC_C_CLR:  taken = !flags.c;
      BC_C_SET:  taken = flags.c;
      BC_Z_SET:  taken = flags.z;
      BC_Z_CLR:  taken = !flags.z;
      BC_N_SET:  taken = flags.n;
      BC_N_CLR:  taken = !flags.n;
      BC_V_SET:  taken = flags.v;
      BC_V_CLR:  taken = !flags.v;
      BC_U_HI:   taken = !flags.c && !flags.z;
      BC_U_LS:   taken = flags.c || flags.z;
      BC_S_GE:   taken = sgn_ok;
      BC_S_LT:   taken = !sgn_ok;
      BC_S_GT:   taken = !flags.z && sgn_ok;
      BC_S_LE:   taken = flags.z || !sgn_ok;
      BC_DEC_NZ: taken = cnt_nz;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brr_target_calc.sv
module brr_target_calc #(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W - 1;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;

  // sign-extend and scale by two in one concatenation
  assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
  assign sum    = pc + offset;
  assign target = {sum[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/brr_out_stage.sv
module brr_out_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (up_valid && up_ready) begin
        full_q <= 1'b1;
        data_q <= up_data;
      end else if (dn_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))) // R11
    else $error("held result changed under back-pressure");

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid) // R10
    else $error("accepted request not presented");
endmodule

// File: rtl/brr_unit.sv
module brr_unit #(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [3:0]        in_cond,
  input  logic              in_flag_c,
  input  logic              in_flag_z,
  input  logic              in_flag_n,
  input  logic              in_flag_v,
  input  logic [DATA_W-1:0] in_dec_val,
  input  logic              in_dec_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_pc,
  output logic              out_taken
);
  import brr_pkg::*;

  localparam int PAY_W = ADDR_W + 1;

  brflags_t          flags;
  brcond_e           cond;
  logic              taken;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] next_pc;
  logic [PAY_W-1:0]  res_d;
  logic [PAY_W-1:0]  res_q;

  assign flags = '{c: in_flag_c, z: in_flag_z, n: in_flag_n, v: in_flag_v};
  assign cond  = brcond_e'(in_cond);

  brr_cond_eval #(.DATA_W(DATA_W), .BYTE_W(8)) u_cond (
    .cond(cond), .flags(flags), .dec_val(in_dec_val),
    .dec_word(in_dec_word), .taken(taken)
  );

  brr_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc(in_pc), .disp(in_disp), .target(target)
  );

  assign next_pc = taken ? target : in_pc;
  assign res_d   = {taken, next_pc};

  brr_out_stage #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(res_d),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(res_q)
  );

  assign out_taken = res_q[PAY_W-1];
  assign out_pc    = res_q[ADDR_W-1:0];

  AST_EVEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken) |-> !out_pc[0]) // R2
    else $error("taken target is odd");

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && in_cond == 4'd0) |-> out_taken) // R4
    else $error("unconditional branch not taken");

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready) && !out_taken) |-> out_pc == $past(in_pc)) // R8
    else $error("not-taken PC altered");

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready) // R10
    else $error("empty stage not ready");
endmodule

// File: tb/sim_brr_unit.sv
module sim_brr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pc = '0;
  logic [7:0]  in_disp = '0;
  logic [3:0]  in_cond = '0;
  logic        in_flag_c = 1'b0, in_flag_z = 1'b0, in_flag_n = 1'b0, in_flag_v = 1'b0;
  logic [15:0] in_dec_val = '0;
  logic        in_dec_word = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pc;
  logic        out_taken;

  int checks = 0;
  int fails = 0;

  // single-slot reference model
  bit          m_valid = 0;
  logic [23:0] m_pc = '0;
  bit          m_taken = 0;
  string       m_tag = "R10";

  always #5 clk = ~clk;

  brr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_disp(in_disp), .in_cond(in_cond),
    .in_flag_c(in_flag_c), .in_flag_z(in_flag_z), .in_flag_n(in_flag_n),
    .in_flag_v(in_flag_v), .in_dec_val(in_dec_val), .in_dec_word(in_dec_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_taken(out_taken)
  );

  function automatic bit ref_taken(int cd, bit c, bit z, bit n, bit v, int dv, bit w);
    case (cd)
      0: return 1;
      1: return c == 0;
      2: return c == 1;
      3: return z == 1;
      4: return z == 0;
      5: return n == 1;
      6: return n == 0;
      7: return v == 1;
      8: return v == 0;
      9: return (c == 0) && (z == 0);
      10: return (c == 1) || (z == 1);
      11: return n == v;
      12: return n != v;
      13: return (z == 0) && (n == v);
      14: return (z == 1) || (n != v);
      default: return w ? (dv % 65536) != 0 : (dv % 256) != 0;
    endcase
  endfunction

  function automatic string tag_of(int cd);
    if (cd == 0) return "R4";
    if (cd <= 4) return "R3";
    if (cd <= 8) return "R5";
    if (cd <= 10) return "R6";
    if (cd <= 14) return "R7";
    return "R9";
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare outputs against the model (called at the falling edge)
  task automatic compare_outputs();
    check("R10", "out_valid", out_valid, m_valid);
    if (m_valid) begin
      check(m_tag, "out_taken", out_taken, m_taken);
      check(m_taken ? "R1/R2" : "R8", "out_pc", out_pc, m_pc);
    end
  endtask

  // apply one cycle of stimulus, then advance model as of the next edge
  task automatic cycle(bit iv, int pc, int dsp, int cd, bit c, bit z, bit n, bit v,
                       int dv, bit w, bit ordy);
    bit t;
    int tgt;
    bit in_fire, out_fire;
    @(negedge clk);
    compare_outputs();
    in_valid = iv; in_pc = pc[23:0]; in_disp = dsp[7:0]; in_cond = cd[3:0];
    in_flag_c = c; in_flag_z = z; in_flag_n = n; in_flag_v = v;
    in_dec_val = dv[15:0]; in_dec_word = w; out_ready = ordy;
    #1;
    check("R10", "in_ready", in_ready, (!m_valid) || ordy);
    in_fire  = iv && in_ready;
    out_fire = m_valid && ordy;
    if (out_fire) m_valid = 0;
    if (in_fire) begin
      t = ref_taken(cd, c, z, n, v, dv, w);
      tgt = (pc % 16777216) + 2 * int'($signed(dsp[7:0]));
      tgt = ((tgt % 16777216) + 16777216) % 16777216;
      tgt = tgt - (tgt % 2);
      m_valid = 1;
      m_taken = t;
      m_pc = t ? tgt[23:0] : pc[23:0];
      m_tag = tag_of(cd);
    end
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset out_valid", out_valid, 0);
    check("R10", "reset in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R4 always taken with all flags set, positive displacement
    cycle(1, 'h001000, 'h10, 0, 1,1,1,1, 0,0, 1);
    // R2 wrap below zero
    cycle(1, 'h000000, 'hFF, 0, 0,0,0,0, 0,0, 1);
    // R2 wrap above top, odd PC
    cycle(1, 'hFFFFFF, 'h01, 0, 0,0,0,0, 0,0, 1);
    // R1 most negative displacement
    cycle(1, 'h000400, 'h80, 2, 1,0,0,0, 0,0, 1);
    // R8 not taken keeps odd PC
    cycle(1, 'h123457, 'h05, 1, 1,0,0,0, 0,0, 1);
    // R3 zero codes
    cycle(1, 'h000100, 'h04, 3, 0,1,0,0, 0,0, 1);
    cycle(1, 'h000100, 'h04, 4, 0,1,0,0, 0,0, 1);
    // R5 sign/overflow
    cycle(1, 'h000200, 'hFE, 5, 0,0,1,0, 0,0, 1);
    cycle(1, 'h000200, 'hFE, 8, 0,0,0,1, 0,0, 1);
    // R6 unsigned compounds
    cycle(1, 'h000300, 'h03, 9, 0,0,0,0, 0,0, 1);
    cycle(1, 'h000300, 'h03, 10, 0,0,0,0, 0,0, 1);
    // R7 signed compounds
    cycle(1, 'h000500, 'h07, 11, 0,0,1,1, 0,0, 1);
    cycle(1, 'h000500, 'h07, 13, 0,1,0,0, 0,0, 1);
    cycle(1, 'h000500, 'h07, 14, 0,0,1,0, 0,0, 1);
    // R9 byte vs word test of 0x0100
    cycle(1, 'h000600, 'hFC, 15, 0,0,0,0, 'h0100, 0, 1);
    cycle(1, 'h000600, 'hFC, 15, 0,0,0,0, 'h0100, 1, 1);
    // R11 stall: hold result while consumer not ready
    cycle(1, 'h000700, 'h11, 0, 0,0,0,0, 0,0, 0);
    cycle(1, 'h000900, 'h22, 0, 0,0,0,0, 0,0, 0);
    cycle(1, 'h000900, 'h22, 0, 0,0,0,0, 0,0, 0);
    cycle(1, 'h000900, 'h22, 0, 0,0,0,0, 0,0, 1);
    cycle(0, 0, 0, 0, 0,0,0,0, 0,0, 1);
    cycle(0, 0, 0, 0, 0,0,0,0, 0,0, 1);

    // random traffic: same-cycle accept and drain, stalls, all selectors
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      cycle(($urandom % 4) != 0, int'($urandom % 16777216), int'($urandom % 256),
            int'($urandom % 16), r[0], r[1], r[2], r[3],
            (r[4] ? 0 : int'($urandom % 65536)), r[5], ($urandom % 3) != 0);
    end
    cycle(0, 0, 0, 0, 0,0,0,0, 0,0, 1);
    cycle(0, 0, 0, 0, 0,0,0,0, 0,0, 1);
    @(negedge clk);
    compare_outputs();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule